// File: doc/BRIEF.md
# Multi-Channel Completion Status Queue

This block collects completion records from four command channels of a storage host controller into a single shared first-in first-out queue. When a channel finishes a command packet it raises a request carrying a 6-bit host status code and an 8-bit device status byte. A round-robin arbiter admits at most one record per clock. The admitted record is stored together with the index of the channel that sent it.

Host software reads the queue through a simple register port as two 32-bit words. The lower word carries the device status byte. The upper word carries the host status, the channel index, a valid flag and an empty flag. Reading the upper word removes the head record, so software drains the queue by reading repeatedly until the empty flag is set. Host status code 0 means the packet completed cleanly and code 3 means the device reported an error; the queue passes both through unchanged.

An interrupt line is active while the queue holds records and the interrupt enable bit is set. A sticky flag records that a record arrived while the queue was full and was discarded.

Top module: `cmpl_status_queue`

## Requirements
- R1: After reset the queue is empty, the interrupt enable is 0, `irq` is 0, `ovf_flag` is 0, and the first arbitration round favours channel 0.
- R2: A read at offset 0x104 of a non-empty queue returns bit 31 = 0 (empty), bit 30 = 1 (valid), bits 9:8 = channel index and bits 5:0 = host status; all other bits are 0. Host status values 0 and 3 are returned as written.
- R3: A read at offset 0x100 of a non-empty queue returns the head's device status in bits 23:16 and zeros elsewhere. It does not remove the head.
- R4: A read at offset 0x104 of a non-empty queue removes the head at that clock edge. Records leave in the order they were admitted.
- R5: While the queue is empty, offset 0x104 reads 0x8000_0000 and offset 0x100 reads 0. A read of 0x104 on an empty queue changes nothing.
- R6: Among simultaneous requests, the grant goes to the first requesting channel after the most recently granted one, in increasing index order with wrap-around. A grant admits the record in the same cycle.
- R7: `push_gnt` has at most one bit set per cycle, and only for a channel whose request is set.
- R8: The queue holds 16 records. A granted record that arrives while the queue is full and no pop occurs in the same cycle is discarded and sets `ovf_flag`, which stays set until reset. When a pop and a push coincide on a full queue, the record is kept.
- R9: A write to offset 0xE4 loads the interrupt enable from data bit 0. A read of 0xE4 returns the enable in bit 0 and zeros elsewhere. Other offsets read 0.
- R10: `irq` equals interrupt enable AND queue not empty, with no added delay after either changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_req | input | 4 | Per-channel completion request, held until granted |
| push_hst | input | 24 | Per-channel host status, 6 bits per channel |
| push_dst | input | 32 | Per-channel device status, 8 bits per channel |
| push_gnt | output | 4 | One-hot grant; the record is taken in this cycle |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq | output | 1 | Interrupt request |
| ovf_flag | output | 1 | Sticky flag: a record was discarded on a full queue |

## Verification
The bound checker watches the grant shape, the bounds on the fill level, the stickiness of the overflow flag, and the empty-read word on every cycle. It also checks that a lower-word read leaves the fill level unchanged, that an upper-word read lowers it by one, and that masking or emptying the queue drops the interrupt. The bench's behavioural model shows what single-cycle properties cannot: the round-robin order across rounds, the order in which records come out, the exact field packing of each word, and which record is lost on overflow.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int CQ_CHAN_W = 2;
  localparam int CQ_HST_W  = 6;
  localparam int CQ_DST_W  = 8;

  typedef struct packed {
    logic [CQ_CHAN_W-1:0] chan;
    logic [CQ_HST_W-1:0]  hst;
    logic [CQ_DST_W-1:0]  dst;
  } cq_rec_t;
endpackage

// File: rtl/cq_rr_arb.sv
module cq_rr_arb #(
  parameter int NUM_CHAN = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_CHAN-1:0]         req,
  output logic [NUM_CHAN-1:0]         gnt,
  output logic [$clog2(NUM_CHAN)-1:0] gnt_idx
);
  localparam int IW = $clog2(NUM_CHAN);

  logic [IW-1:0] last_q;
  logic [IW-1:0] last_d;
  logic          any_req;

  assign any_req = |req;

  // search starts just after the last winner, wrapping around
  always_comb begin
    logic found;
    int   idx;
    gnt    = '0;
    last_d = last_q;
    found  = 1'b0;
    for (int k = 1; k <= NUM_CHAN; k++) begin
      idx = (int'(last_q) + k) % NUM_CHAN;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        last_d   = IW'(idx);
        found    = 1'b1;
      end
    end
  end

  assign gnt_idx = last_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= IW'(NUM_CHAN - 1);
    end else if (any_req) begin
      last_q <= last_d;
    end
  end
endmodule

// File: rtl/cq_fifo.sv
module cq_fifo
  import cq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  cq_rec_t                    push_rec,
  input  logic                       pop,
  output cq_rec_t                    head,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       dropped
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  cq_rec_t       mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, do_pop, do_push;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dropped = push && full && !do_pop;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = do_push ? adv(wr_q) : wr_q;
    rd_d  = do_pop  ? adv(rd_q) : rd_q;
    cnt_d = cnt_q;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // storage carries no reset; contents are masked while empty
  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_rec;
  end

  assign head  = mem_q[rd_q];
  assign count = cnt_q;
endmodule

// File: rtl/cq_regs.sv
module cq_regs
  import cq_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter int          DATA_W  = 32,
  parameter logic [11:0] LO_OFS  = 12'h100,
  parameter logic [11:0] HI_OFS  = 12'h104,
  parameter logic [11:0] IEN_OFS = 12'h0E4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  cq_rec_t           head,
  input  logic              empty,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pop,
  output logic              int_en
);
  localparam int EMPTY_BIT = 31;
  localparam int VALID_BIT = 30;
  localparam int CHAN_LSB  = 8;
  localparam int DST_LSB   = 16;

  logic en_q, en_d;
  logic hit_lo, hit_hi, hit_ien;

  assign hit_lo  = (reg_addr == ADDR_W'(LO_OFS));
  assign hit_hi  = (reg_addr == ADDR_W'(HI_OFS));
  assign hit_ien = (reg_addr == ADDR_W'(IEN_OFS));

  assign pop = reg_rd && hit_hi && !empty;

  always_comb begin
    en_d = en_q;
    if (reg_wr && hit_ien) en_d = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_hi) begin
      if (empty) begin
        reg_rdata[EMPTY_BIT] = 1'b1;
      end else begin
        reg_rdata[VALID_BIT] = 1'b1;
        reg_rdata[CHAN_LSB +: CQ_CHAN_W] = head.chan;
        reg_rdata[0 +: CQ_HST_W]         = head.hst;
      end
    end else if (hit_lo) begin
      if (!empty) reg_rdata[DST_LSB +: CQ_DST_W] = head.dst;
    end else if (hit_ien) begin
      reg_rdata[0] = en_q;
    end
  end

  assign int_en = en_q;
endmodule

// File: rtl/cmpl_status_queue.sv
module cmpl_status_queue
  import cq_pkg::*;
#(
  parameter int          NUM_CHAN = 4,
  parameter int          DEPTH    = 16,
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter logic [11:0] LO_OFS   = 12'h100,
  parameter logic [11:0] HI_OFS   = 12'h104,
  parameter logic [11:0] IEN_OFS  = 12'h0E4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_CHAN-1:0]          push_req,
  input  logic [NUM_CHAN*CQ_HST_W-1:0] push_hst,
  input  logic [NUM_CHAN*CQ_DST_W-1:0] push_dst,
  output logic [NUM_CHAN-1:0]          push_gnt,
  input  logic                         reg_rd,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  output logic                         irq,
  output logic                         ovf_flag
);
  localparam int IW = $clog2(NUM_CHAN);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rst_meta, rst_sync;
  logic [IW-1:0] gnt_idx;
  cq_rec_t       in_rec, head;
  logic          pop, empty, dropped, int_en;
  logic [CW-1:0] fill_cnt;
  logic          ovf_q, ovf_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  cq_rr_arb #(.NUM_CHAN(NUM_CHAN)) u_arb (
    .clk     (clk),
    .rst_n   (rst_sync),
    .req     (push_req),
    .gnt     (push_gnt),
    .gnt_idx (gnt_idx)
  );

  always_comb begin
    in_rec.chan = CQ_CHAN_W'(gnt_idx);
    in_rec.hst  = push_hst[gnt_idx*CQ_HST_W +: CQ_HST_W];
    in_rec.dst  = push_dst[gnt_idx*CQ_DST_W +: CQ_DST_W];
  end

  cq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_sync),
    .push     (|push_gnt),
    .push_rec (in_rec),
    .pop      (pop),
    .head     (head),
    .empty    (empty),
    .count    (fill_cnt),
    .dropped  (dropped)
  );

  cq_regs #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W),
    .LO_OFS (LO_OFS), .HI_OFS (HI_OFS), .IEN_OFS (IEN_OFS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .head      (head),
    .empty     (empty),
    .reg_rdata (reg_rdata),
    .pop       (pop),
    .int_en    (int_en)
  );

  always_comb ovf_d = ovf_q | dropped;

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) ovf_q <= 1'b0;
    else           ovf_q <= ovf_d;
  end

  assign ovf_flag = ovf_q;
  assign irq      = int_en && !empty;
endmodule

// File: rtl/cq_checker.sv
module cq_checker #(
  parameter int          NUM_CHAN = 4,
  parameter int          DEPTH    = 16,
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter logic [11:0] LO_OFS   = 12'h100,
  parameter logic [11:0] HI_OFS   = 12'h104,
  parameter logic [11:0] IEN_OFS  = 12'h0E4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_CHAN-1:0]        push_req,
  input logic [NUM_CHAN-1:0]        push_gnt,
  input logic                       reg_rd,
  input logic                       reg_wr,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [DATA_W-1:0]          reg_wdata,
  input logic [DATA_W-1:0]          reg_rdata,
  input logic                       irq,
  input logic                       ovf_flag,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int CW = $clog2(DEPTH + 1);

  logic rd_hi, rd_lo;
  assign rd_hi = reg_rd && (reg_addr == ADDR_W'(HI_OFS));
  assign rd_lo = reg_rd && (reg_addr == ADDR_W'(LO_OFS));

  assert_gnt_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(push_gnt));

  assert_gnt_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_gnt & ~push_req) == '0);

  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_pop_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && fill != '0 && push_req == '0) |=> fill == $past(fill) - 1'b1);

  assert_lo_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && push_req == '0) |=> fill == $past(fill));

  assert_empty_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && fill == '0) |-> reg_rdata == DATA_W'(32'h8000_0000));

  assert_irq_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> !irq);

  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(IEN_OFS) && !reg_wdata[0]) |=> !irq);
endmodule

bind cmpl_status_queue cq_checker #(
  .NUM_CHAN (NUM_CHAN), .DEPTH (DEPTH), .ADDR_W (ADDR_W), .DATA_W (DATA_W),
  .LO_OFS (LO_OFS), .HI_OFS (HI_OFS), .IEN_OFS (IEN_OFS)
) u_cq_checker (
  .clk       (clk),
  .rst_n     (rst_sync),
  .push_req  (push_req),
  .push_gnt  (push_gnt),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .ovf_flag  (ovf_flag),
  .fill      (fill_cnt)
);

// File: tb/test_cmpl_status_queue.sv
`timescale 1ns/1ps
module test_cmpl_status_queue;
  localparam int N = 4;
  localparam int D = 16;
  localparam logic [11:0] A_LO  = 12'h100;
  localparam logic [11:0] A_HI  = 12'h104;
  localparam logic [11:0] A_IEN = 12'h0E4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  push_req = '0;
  logic [N*6-1:0] push_hst = '0;
  logic [N*8-1:0] push_dst = '0;
  logic [N-1:0]  push_gnt;
  logic          reg_rd = 1'b0, reg_wr = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0, reg_rdata;
  logic          irq, ovf_flag;

  always #4 clk = ~clk;

  cmpl_status_queue i_cmpl_status_queue (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_hst(push_hst),
    .push_dst(push_dst), .push_gnt(push_gnt), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .ovf_flag(ovf_flag)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  // reference model state
  logic [15:0] mq[$];
  bit          m_en = 0, m_ovf = 0;
  int          m_last = N - 1;
  logic [N-1:0] g_seen = '0;

  function automatic logic [N-1:0] exp_gnt(int last, logic [N-1:0] req);
    for (int k = 1; k <= N; k++)
      if (req[(last + k) % N]) return N'(1) << ((last + k) % N);
    return '0;
  endfunction

  function automatic logic [31:0] exp_rdata(logic [11:0] a);
    logic [15:0] h;
    if (mq.size() == 0) return (a == A_HI) ? 32'h8000_0000 :
                               (a == A_IEN) ? {31'd0, m_en} : 32'd0;
    h = mq[0];
    if (a == A_HI)  return 32'h4000_0000 | ({30'd0, h[15:14]} << 8) | {26'd0, h[13:8]};
    if (a == A_LO)  return {8'd0, h[7:0], 16'd0};
    if (a == A_IEN) return {31'd0, m_en};
    return 32'd0;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // model update on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_en = 0; m_ovf = 0; m_last = N - 1;
    end else begin
      logic [N-1:0] g;
      bit full, pop;
      g    = exp_gnt(m_last, push_req);
      full = (mq.size() == D);
      pop  = reg_rd && reg_addr == A_HI && mq.size() > 0;
      if (pop) void'(mq.pop_front());
      for (int c = 0; c < N; c++) if (g[c]) begin
        m_last = c;
        if (!full || pop) mq.push_back({2'(c), push_hst[c*6 +: 6], push_dst[c*8 +: 8]});
        else m_ovf = 1;
      end
      if (reg_wr && reg_addr == A_IEN) m_en = reg_wdata[0];
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [N-1:0] eg;
      logic [31:0]  er;
      string tag;
      eg = exp_gnt(m_last, push_req);
      er = exp_rdata(reg_addr);
      tag = (reg_addr == A_HI) ? (mq.size() == 0 ? "R5" : "R2") :
            (reg_addr == A_LO) ? (mq.size() == 0 ? "R5" : "R3") : "R9";
      chk(push_gnt === eg, "R6 grant", 32'(push_gnt), 32'(eg));
      chk($countones(push_gnt) <= 1, "R7 onehot", 32'(push_gnt), 32'(eg));
      chk(reg_rdata === er, tag, reg_rdata, er);
      chk(irq === (m_en && mq.size() > 0), "R10 irq", 32'(irq), 32'(m_en && mq.size() > 0));
      chk(ovf_flag === m_ovf, "R8 ovf", 32'(ovf_flag), 32'(m_ovf));
      g_seen = push_gnt;
    end
  end

  task automatic step();
    @(posedge clk); #1;
    push_req = push_req & ~g_seen;
    reg_rd = 0; reg_wr = 0;
  endtask

  task automatic post(int c, logic [5:0] h, logic [7:0] d);
    push_req[c] = 1'b1;
    push_hst[c*6 +: 6] = h;
    push_dst[c*8 +: 8] = d;
  endtask

  task automatic rd_word(logic [11:0] a, output logic [31:0] v);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); v = reg_rdata;
    step();
  endtask

  task automatic wr_word(logic [11:0] a, logic [31:0] v);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    repeat (4) step();

    // R1: reset state
    @(negedge clk);
    chk(irq === 0 && ovf_flag === 0 && push_gnt === 0, "R1 reset outputs",
        {29'd0, irq, ovf_flag, |push_gnt}, 0);
    step();
    rd_word(A_IEN, v);  chk(v === 0, "R1 enable cleared", v, 0);
    rd_word(A_HI, v);   chk(v === 32'h8000_0000, "R5 empty upper", v, 32'h8000_0000);
    rd_word(A_LO, v);   chk(v === 0, "R5 empty lower", v, 0);
    rd_word(12'h200, v); chk(v === 0, "R9 unmapped", v, 0);

    // R9: enable write / readback
    wr_word(A_IEN, 32'h1);
    rd_word(A_IEN, v);  chk(v === 1, "R9 enable readback", v, 1);

    // R2/R3/R10: single record, device error status
    post(2, 6'd3, 8'h51);
    step();
    @(negedge clk); chk(irq === 1, "R10 irq raised", 32'(irq), 1);
    step();
    rd_word(A_LO, v);   chk(v === 32'h0051_0000, "R3 lower word", v, 32'h0051_0000);
    rd_word(A_LO, v);   chk(v === 32'h0051_0000, "R3 lower read no pop", v, 32'h0051_0000);
    rd_word(A_HI, v);   chk(v === 32'h4000_0203, "R2 upper word", v, 32'h4000_0203);
    rd_word(A_HI, v);   chk(v === 32'h8000_0000, "R4 popped to empty", v, 32'h8000_0000);

    // R6: all four at once after channel 2 won last -> order 3,0,1,2
    for (int c = 0; c < N; c++) post(c, 6'(c == 1 ? 0 : c + 8), 8'(8'h10 + c));
    repeat (5) step();
    for (int k = 0; k < N; k++) begin
      int ec;
      ec = (3 + k) % N;
      rd_word(A_HI, v);
      chk(v[9:8] === 2'(ec), "R6 round-robin order", 32'(v[9:8]), 32'(ec));
    end

    // R8: overflow by 17 records from channel 1, then drain in order
    for (int i = 0; i < D + 1; i++) begin
      post(1, 6'(i), 8'(i));
      step();
    end
    step();
    @(negedge clk); chk(ovf_flag === 1, "R8 overflow set", 32'(ovf_flag), 1);
    step();
    // R8: pop and push together on a full queue keeps the record
    post(0, 6'd0, 8'hEE); reg_rd = 1; reg_addr = A_HI;
    step();
    step();
    // R10: masking drops irq while records remain
    wr_word(A_IEN, 32'h0);
    @(negedge clk); chk(irq === 0, "R10 masked", 32'(irq), 0);
    step();
    for (int i = 1; i < D; i++) begin
      rd_word(A_LO, v);
      chk(v[23:16] === 8'(i), "R4 fifo order", 32'(v[23:16]), 32'(i));
      rd_word(A_HI, v);
    end
    rd_word(A_HI, v);   chk(v === 32'h4000_0000, "R2 success code 0 ch0", v, 32'h4000_0000);
    rd_word(A_HI, v);   chk(v === 32'h8000_0000, "R5 drained", v, 32'h8000_0000);
    @(negedge clk); chk(ovf_flag === 1, "R8 overflow sticky", 32'(ovf_flag), 1);
    step();
    finish_run();
  end
endmodule